// File: doc/BRIEF.md
# Narrow-Bus Pixel Serializer

This block sits between a pixel source and the data pins of a TFT panel. It takes one pixel per valid/ready handshake and drives it onto a parallel bus as one 16-bit beat, two 8-bit beats or three 8-bit beats. A mode input selects the format: RGB565 on a 16-bit bus, RGB565 on an 8-bit bus, or RGB888 on an 8-bit bus. A colour-order input says whether red and blue are swapped in the incoming word. The block always puts red in the most significant field on the bus.

The block waits a fixed number of extra cycles between accepting a pixel and driving its first beat. This number depends on the mode: 0 for the 16-bit bus, 3 for RGB565 over 8 bits and 5 for RGB888 over 8 bits. The offset between the external sync pulses and the first valid pixel can therefore be computed from the mode alone.

The control is a three-state machine:
- `ST_IDLE`: waiting for a pixel.
- `ST_HOLD`: the added delay is counting down.
- `ST_BEAT`: beats are on the bus.

Transitions:
- idle→beat (accept, no delay)
- idle→hold (accept, delay needed)
- hold→hold (count down)
- hold→beat (delay expired)
- beat→beat (next beat, or accept on the last beat)
- beat→hold (accept on the last beat, delay needed)
- beat→idle (last beat, no new pixel)

Top module: `pix_narrow_ser`

## Requirements
- R1: After reset `bus_strobe` is 0, `bus_data` is 0 and `pix_ready` is 1.
- R2: `mode_sel` encodings: 0 gives one 16-bit beat per pixel, 1 gives two 8-bit beats, 2 gives three 8-bit beats. The value 3 behaves exactly like 0.
- R3: For 16-bit pixels (`pix_data[15:0]`) with `bgr_in`=0, red is taken from bits 15:11, green from 10:5 and blue from 4:0. With `bgr_in`=1, red is taken from 4:0, green from 10:5 and blue from 15:11. The word sent is always {red, green, blue}, and `pix_data[23:16]` is ignored.
- R4: For 24-bit pixels with `bgr_in`=0, red is taken from bits 23:16, green from 15:8 and blue from 7:0. With `bgr_in`=1, red is taken from 7:0 and blue from 23:16. Beats are sent in the order red, green, blue.
- R5: On the 8-bit bus the most significant byte goes first. Beats appear on `bus_data[7:0]`, and `bus_data[15:8]` is 0. In 16-bit mode the whole word is on `bus_data[15:0]`. `bus_data` is 0 whenever `bus_strobe` is 0.
- R6: If a pixel is accepted at clock edge A, its first beat is driven in the cycle after edge A+D, where D is 0, 3 or 5 for modes 0, 1 and 2.
- R7: `pix_ready` is 1 only while idle or during the last beat of the current pixel. A pixel is accepted at an edge where `pix_valid` and `pix_ready` are both 1.
- R8: In 16-bit mode, with `pix_valid` held high, one pixel is accepted and one beat is driven every cycle, with no gap.
- R9: `mode_sel`, `bgr_in` and `pix_data` are sampled at acceptance. Changing them afterwards does not affect that pixel.
- R10: The beats of one pixel are driven in consecutive cycles, with `bus_strobe` high for each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Bus format select |
| bgr_in | input | 1 | 1 = red and blue swapped in the input word |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel can be taken this cycle |
| pix_data | input | 24 | Pixel word |
| bus_data | output | 16 | Panel data bus |
| bus_strobe | output | 1 | A beat is on `bus_data` |

## Verification
The bench checks the exact cycle of the first beat for each of the three formats. A serializer with a wrong delay count, or one that drops the delay in a narrow mode, shows its strobe a cycle early or late.

It checks both colour orders in each pixel width. A swapped or misplaced field gives wrong byte values. Sending bytes in the wrong order, or leaving data on the upper lane in narrow modes, is also caught.

It checks `pix_ready` in every cycle of a pixel. This catches a design that takes a new pixel in the middle of another. It also changes the mode and colour-order inputs right after acceptance, which catches a design that reads them live instead of latching them.

A full-rate 16-bit stream and the reserved mode code complete the set. A bubble between pixels, or a third beat on code 3, would show.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

    typedef enum logic [1:0] {
        MODE_W16    = 2'd0,
        MODE_565_B8 = 2'd1,
        MODE_888_B8 = 2'd2,
        MODE_RSVD   = 2'd3
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_BEAT = 2'd2
    } ser_state_e;

    // The reserved code is folded onto the wide-bus format
    function automatic bus_mode_e eff_mode(input logic [1:0] m);
        return (m == MODE_RSVD) ? MODE_W16 : bus_mode_e'(m);
    endfunction

    function automatic logic [1:0] beats_of(input bus_mode_e m);
        unique case (m)
            MODE_565_B8: return 2'd2;
            MODE_888_B8: return 2'd3;
            default:     return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/pix_field_order.sv
module pix_field_order
    import pix_ser_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  bus_mode_e        mode,
    input  logic             bgr,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] word_out
);
    localparam int CH8   = PIX_W / 3;
    localparam int W16   = 16;
    localparam int PAD   = PIX_W - W16;

    logic [W16-1:0] w565;
    logic [PIX_W-1:0] w888;

    always_comb begin
        if (bgr) w565 = {pix_in[4:0], pix_in[10:5], pix_in[15:11]};
        else     w565 = pix_in[W16-1:0];

        if (bgr) w888 = {pix_in[CH8-1:0], pix_in[2*CH8-1:CH8], pix_in[3*CH8-1:2*CH8]};
        else     w888 = pix_in;

        // Left-align so the first beat always comes from the top bits
        if (mode == MODE_888_B8) word_out = w888;
        else                     word_out = {w565, {PAD{1'b0}}};
    end

endmodule

// File: rtl/pix_beat_seq.sv
module pix_beat_seq
    import pix_ser_pkg::*;
#(
    parameter int BUS_W       = 16,
    parameter int PIX_W       = 24,
    parameter int DLY_565_B8  = 3,
    parameter int DLY_888_B8  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_mode_e        mode_in,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] word_in,
    output logic             pix_ready,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_strobe
);
    localparam int BYTE_W  = BUS_W / 2;
    localparam int DLY_MAX = (DLY_565_B8 > DLY_888_B8) ? DLY_565_B8 : DLY_888_B8;
    localparam int CNT_W   = $clog2(DLY_MAX + 2);

    ser_state_e       state_q, state_n;
    bus_mode_e        mode_q, mode_n;
    logic [CNT_W-1:0] wait_q, wait_n;
    logic [1:0]       beat_q, beat_n;
    logic [PIX_W-1:0] shift_q, shift_n;

    logic accept, last_beat;
    logic [CNT_W-1:0] start_dly;

    always_comb begin
        unique case (mode_in)
            MODE_565_B8: start_dly = CNT_W'(DLY_565_B8);
            MODE_888_B8: start_dly = CNT_W'(DLY_888_B8);
            default:     start_dly = '0;
        endcase
    end

    assign last_beat = (beat_q == beats_of(mode_q) - 2'd1);
    assign pix_ready = (state_q == ST_IDLE) || (state_q == ST_BEAT && last_beat);
    assign accept    = pix_valid && pix_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_W16;
            wait_q  <= '0;
            beat_q  <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_n;
            mode_q  <= mode_n;
            wait_q  <= wait_n;
            beat_q  <= beat_n;
            shift_q <= shift_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        mode_n  = mode_q;
        wait_n  = wait_q;
        beat_n  = beat_q;
        shift_n = shift_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_HOLD: begin
                if (wait_q == CNT_W'(1)) begin
                    state_n = ST_BEAT;
                    beat_n  = '0;
                end else begin
                    wait_n = wait_q - CNT_W'(1);
                end
            end
            ST_BEAT: begin
                if (last_beat) begin
                    state_n = ST_IDLE;
                end else begin
                    beat_n  = beat_q + 2'd1;
                    shift_n = shift_q << BYTE_W;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (accept) begin
            mode_n  = mode_in;
            shift_n = word_in;
            beat_n  = '0;
            wait_n  = start_dly;
            state_n = (start_dly == '0) ? ST_BEAT : ST_HOLD;
        end
    end

    // Output logic
    always_comb begin
        bus_strobe = 1'b0;
        bus_data   = '0;
        unique case (state_q)
            ST_BEAT: begin
                bus_strobe = 1'b1;
                if (mode_q == MODE_W16) bus_data = shift_q[PIX_W-1 -: BUS_W];
                else                    bus_data = {{BYTE_W{1'b0}}, shift_q[PIX_W-1 -: BYTE_W]};
            end
            default: ;
        endcase
    end

    // R6: the wide format drives its beat right after acceptance
    p_wide_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_in == MODE_W16) |=> bus_strobe);

    // R6: narrow formats stay quiet for at least one cycle
    p_narrow_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_in != MODE_W16) |=> !bus_strobe);

    // R9: the held pixel is untouched while the delay runs
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> ($stable(shift_q) && $stable(mode_q)));

    // R10: a beat that is not the last is always followed by another beat
    p_beats_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && !pix_ready) |=> bus_strobe);

    // R5: the upper lane is clear on the narrow bus
    p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && mode_q != MODE_W16) |-> (bus_data[BUS_W-1:BYTE_W] == '0));

endmodule

// File: rtl/pix_narrow_ser.sv
module pix_narrow_ser
    import pix_ser_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int PIX_W      = 24,
    parameter int DLY_565_B8 = 3,
    parameter int DLY_888_B8 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             bgr_in,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [PIX_W-1:0] pix_data,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_strobe
);
    bus_mode_e        mode_eff;
    logic [PIX_W-1:0] ordered;

    assign mode_eff = eff_mode(mode_sel);

    pix_field_order #(.PIX_W(PIX_W)) u_order (
        .mode     (mode_eff),
        .bgr      (bgr_in),
        .pix_in   (pix_data),
        .word_out (ordered)
    );

    pix_beat_seq #(
        .BUS_W      (BUS_W),
        .PIX_W      (PIX_W),
        .DLY_565_B8 (DLY_565_B8),
        .DLY_888_B8 (DLY_888_B8)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_in    (mode_eff),
        .pix_valid  (pix_valid),
        .word_in    (ordered),
        .pix_ready  (pix_ready),
        .bus_data   (bus_data),
        .bus_strobe (bus_strobe)
    );

endmodule

// File: tb/test_pix_narrow_ser.sv
`timescale 1ns/1ps
module test_pix_narrow_ser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        bgr_in = 1'b0;
    logic        pix_valid = 1'b0;
    logic        pix_ready;
    logic [23:0] pix_data = '0;
    logic [15:0] bus_data;
    logic        bus_strobe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pix_narrow_ser i_pix_narrow_ser (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bgr_in(bgr_in),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .bus_data(bus_data), .bus_strobe(bus_strobe)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_beat(input int em, input logic b,
                                             input logic [23:0] d, input int k);
        logic [15:0] w;
        logic [7:0]  r8, g8, b8;
        if (em == 2) begin
            r8 = b ? d[7:0] : d[23:16];
            g8 = d[15:8];
            b8 = b ? d[23:16] : d[7:0];
            return (k == 0) ? {8'h0, r8} : (k == 1) ? {8'h0, g8} : {8'h0, b8};
        end
        w = b ? {d[4:0], d[10:5], d[15:11]} : d[15:0];
        if (em == 0) return w;
        return (k == 0) ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
    endfunction

    // One pixel, then every cycle until idle: strobe, data and ready
    task automatic run_pixel(input logic [1:0] m, input logic b, input logic [23:0] d,
                             input logic [1:0] m_after, input string req);
        int em, nb, dly, guard, k;
        em  = (m == 2'd3) ? 0 : int'(m);
        nb  = em + 1;
        dly = (em == 0) ? 0 : (em == 1) ? 3 : 5;
        @(negedge clk);
        mode_sel = m; bgr_in = b; pix_data = d; pix_valid = 1'b1;
        guard = 0;
        while (!pix_ready && guard < 50) begin @(negedge clk); guard++; end
        @(posedge clk);
        @(negedge clk);
        pix_valid = 1'b0; pix_data = ~d; mode_sel = m_after; bgr_in = ~b;
        for (int j = 0; j <= dly + nb; j++) begin
            if (j > 0) @(negedge clk);
            k = j - dly;
            if (j >= dly && j < dly + nb) begin
                check(32'(bus_strobe), 32'd1, (k == 0) ? "R6" : "R10");
                check(32'(bus_data), 32'(exp_beat(em, b, d, k)), req);
            end else begin
                check(32'(bus_strobe), 32'd0, (j < dly) ? "R6" : "R2");
                check(32'(bus_data), 32'd0, "R5");
            end
            check(32'(pix_ready), 32'(j >= dly + nb - 1), "R7");
        end
    endtask

    task automatic test_reset;
        check(32'(bus_strobe), 32'd0, "R1");
        check(32'(bus_data), 32'd0, "R1");
        check(32'(pix_ready), 32'd1, "R1");
    endtask

    // R8: full-rate stream on the wide bus, upper input byte set to junk
    task automatic test_stream;
        logic [23:0] d;
        @(negedge clk);
        mode_sel = 2'd0; bgr_in = 1'b0; pix_valid = 1'b1;
        pix_data = {8'hAA, 16'h1234};
        for (int i = 0; i < 4; i++) begin
            d = pix_data;
            @(posedge clk);
            @(negedge clk);
            check(32'(bus_strobe), 32'd1, "R8");
            check(32'(bus_data), 32'(d[15:0]), "R8");
            check(32'(pix_ready), 32'd1, "R8");
            pix_data = {8'h55, d[15:0] + 16'h1111};
        end
        pix_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(32'(bus_strobe), 32'd0, "R8");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_pixel(2'd0, 1'b0, 24'hFFF81F, 2'd0, "R3");
        run_pixel(2'd0, 1'b1, 24'h00F81F, 2'd0, "R3");
        run_pixel(2'd1, 1'b0, 24'h00A5C3, 2'd1, "R5");
        run_pixel(2'd1, 1'b1, 24'h00A5C3, 2'd1, "R3");
        run_pixel(2'd2, 1'b0, 24'h123456, 2'd2, "R4");
        run_pixel(2'd2, 1'b1, 24'h123456, 2'd2, "R4");
        run_pixel(2'd2, 1'b0, 24'hC0FFEE, 2'd0, "R9");
        run_pixel(2'd1, 1'b1, 24'h003E41, 2'd2, "R9");
        run_pixel(2'd3, 1'b0, 24'hEE7B9D, 2'd1, "R2");
        test_stream();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule